// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block is the digital controller of a dual-slope integrating analog-to-digital converter. It runs a repeating measurement cycle of three phases. First it auto-zeroes for a fixed number of clocks. Then it integrates the unknown signal for a fixed number of clocks. Last it de-integrates against the reference and counts clocks until the integrator comparator reports a zero crossing. That count is the conversion result. The analog switches, the integrator and the comparators sit outside the block. Their two comparator outputs arrive as synchronous digital inputs.

The block drives a busy flag that covers both integration phases. It keeps three status flags: overrange, underrange and polarity. Each flag has its own set and clear point within the cycle. When a measurement ends, the block presents the count and pulses a one-clock load strobe. Downstream latches or a processor can capture the result on that strobe. After a long reference phase with no crossing, the block aborts the measurement. It flags overrange and reports a saturated count.

Top module: `dual_slope_seq`

## Requirements
- R1: While `rst` is high on a clock edge, the block returns to the first clock of auto-zero. That edge clears `busy_o`, `overrange_o`, `underrange_o`, `polarity_o`, `load_o` and `count_o`.
- R2: Auto-zero lasts `AZ_CNT` clocks with `busy_o` low. `busy_o` rises on the `AZ_CNT`-th clock edge after the reset edge or after the load edge.
- R3: Signal integration lasts `SI_CNT` clocks. `pol_cmp_i` is sampled only on the last of them, where 1 means a positive input. `polarity_o` takes that value at the edge that starts reference integration and holds it until the next such edge, including for a zero result.
- R4: During reference integration, `busy_o` stays high. It falls on the first edge at which `zero_cross_i` is high. The result is the number of earlier reference-integration edges, which can be 0.
- R5: If `zero_cross_i` is still low on the reference edge whose count equals `OR_LIMIT`, the measurement aborts at that edge. `busy_o` falls, `overrange_o` is set and the reported count is `OR_LIMIT`.
- R6: `overrange_o` holds through the following auto-zero and signal integration. It clears at the edge that starts the next reference integration.
- R7: When `busy_o` falls on a zero crossing, `underrange_o` is set if the result is `UR_MAX` or less, and cleared otherwise. It stays low on an overrange abort. It clears at the edge where `busy_o` next rises.
- R8: `load_o` is high for exactly one clock, the clock after `busy_o` falls. `count_o` takes the new result at that same edge and holds it until the next load.
- R9: `zero_cross_i` has no effect outside reference integration. Toggling it during auto-zero or signal integration leaves the phase timing and the result unchanged.
- R10: A reset in the middle of a measurement abandons it. The next measurement then runs normally from auto-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| zero_cross_i | input | 1 | Integrator comparator, high when the zero crossing is detected |
| pol_cmp_i | input | 1 | Polarity comparator, high for a positive input |
| busy_o | output | 1 | High during signal and reference integration |
| overrange_o | output | 1 | Last measurement aborted at the count limit |
| underrange_o | output | 1 | Last result was at or below the underrange threshold |
| polarity_o | output | 1 | Polarity of the last measurement, 1 = positive |
| load_o | output | 1 | One-clock strobe marking a new result on `count_o` |
| count_o | output | CNT_W | Result of the last measurement |

## Verification
Assertions check, on every clock, that busy is low in auto-zero and in the load slot and high in both integration phases. They also check that the reference count never passes the limit, that the load strobe lasts one clock and follows the fall of busy, that overrange rises only as busy falls, that underrange is low when busy rises, and that polarity changes only on entry to reference integration. Only the bench scenarios can show the exact phase lengths, the result value for each crossing time, and the threshold edges at `UR_MAX` and `OR_LIMIT`. The same holds for the last-clock polarity sampling, for flag persistence across whole cycles, for immunity to crossing glitches outside reference integration, and for recovery from a reset mid-measurement.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [1:0] {
    PH_AZ   = 2'd0,
    PH_SI   = 2'd1,
    PH_RI   = 2'd2,
    PH_DONE = 2'd3
  } dsc_phase_e;
endpackage

// File: rtl/dsc_phase_ctrl.sv
module dsc_phase_ctrl
  import dsc_pkg::*;
#(
  parameter int AZ_CNT   = 10001,
  parameter int SI_CNT   = 10000,
  parameter int OR_LIMIT = 20000,
  parameter int CNT_W    = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             zc_i,
  output dsc_phase_e       phase_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             si_start_o,
  output logic             ri_start_o,
  output logic             end_ok_o,
  output logic             end_ovr_o
);
  localparam logic [CNT_W-1:0] AZ_LAST = CNT_W'(AZ_CNT - 1);
  localparam logic [CNT_W-1:0] SI_LAST = CNT_W'(SI_CNT - 1);
  localparam logic [CNT_W-1:0] RI_MAX  = CNT_W'(OR_LIMIT);

  // phase boundary events, decoded from the current phase and count
  always_comb begin
    si_start_o = (phase_o == PH_AZ) && (cnt_o == AZ_LAST);
    ri_start_o = (phase_o == PH_SI) && (cnt_o == SI_LAST);
    end_ok_o   = (phase_o == PH_RI) && zc_i;
    end_ovr_o  = (phase_o == PH_RI) && !zc_i && (cnt_o == RI_MAX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_o <= PH_AZ;
      cnt_o   <= '0;
    end else begin
      case (phase_o)
        PH_AZ: begin
          if (si_start_o) begin
            phase_o <= PH_SI;
            cnt_o   <= '0;
          end else begin
            cnt_o <= cnt_o + 1'b1;
          end
        end
        PH_SI: begin
          if (ri_start_o) begin
            phase_o <= PH_RI;
            cnt_o   <= '0;
          end else begin
            cnt_o <= cnt_o + 1'b1;
          end
        end
        PH_RI: begin
          if (end_ok_o || end_ovr_o) begin
            phase_o <= PH_DONE;
          end else begin
            cnt_o <= cnt_o + 1'b1;
          end
        end
        default: begin
          phase_o <= PH_AZ;
          cnt_o   <= '0;
        end
      endcase
    end
  end

  AST_RI_BOUND: assert property (@(posedge clk) disable iff (rst)
    (phase_o == PH_RI) |-> (cnt_o <= RI_MAX)); // R5

  AST_DONE_ONE_SLOT: assert property (@(posedge clk) disable iff (rst)
    (phase_o == PH_DONE) |=> (phase_o == PH_AZ) && (cnt_o == '0)); // R8

endmodule

// File: rtl/dsc_status.sv
module dsc_status #(
  parameter int UR_MAX = 1800,
  parameter int CNT_W  = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             si_start_i,
  input  logic             ri_start_i,
  input  logic             end_ok_i,
  input  logic             end_ovr_i,
  input  logic             pol_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             busy_o,
  output logic             ovr_o,
  output logic             ur_o,
  output logic             pol_o
);
  localparam logic [CNT_W-1:0] UR_LIM = CNT_W'(UR_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      ovr_o  <= 1'b0;
      ur_o   <= 1'b0;
      pol_o  <= 1'b0;
    end else begin
      if (si_start_i) begin
        busy_o <= 1'b1;
        ur_o   <= 1'b0;
      end
      if (ri_start_i) begin
        pol_o <= pol_i;
        ovr_o <= 1'b0;
      end
      if (end_ok_i) begin
        busy_o <= 1'b0;
        ur_o   <= (cnt_i <= UR_LIM);
      end
      if (end_ovr_i) begin
        busy_o <= 1'b0;
        ovr_o  <= 1'b1;
      end
    end
  end

  AST_OVR_ON_BUSY_FALL: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_o) |-> $fell(busy_o)); // R5

  AST_UR_LOW_AT_BUSY_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> !ur_o); // R7

endmodule

// File: rtl/dsc_result.sv
module dsc_result #(
  parameter int OR_LIMIT = 20000,
  parameter int CNT_W    = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             end_ok_i,
  input  logic             end_ovr_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             load_o,
  output logic [CNT_W-1:0] result_o
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(OR_LIMIT);

  logic             pend_q;
  logic [CNT_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= 1'b0;
      hold_q   <= '0;
      load_o   <= 1'b0;
      result_o <= '0;
    end else begin
      pend_q <= end_ok_i || end_ovr_i;
      if (end_ok_i)       hold_q <= cnt_i;
      else if (end_ovr_i) hold_q <= SAT;
      load_o <= pend_q;
      if (pend_q) result_o <= hold_q;
    end
  end

  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    load_o |=> !load_o); // R8

endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
  import dsc_pkg::*;
#(
  parameter int AZ_CNT   = 10001,
  parameter int SI_CNT   = 10000,
  parameter int OR_LIMIT = 20000,
  parameter int UR_MAX   = 1800,
  localparam int MAX_A   = (AZ_CNT > SI_CNT) ? AZ_CNT : SI_CNT,
  localparam int MAX_ALL = (MAX_A > OR_LIMIT) ? MAX_A : OR_LIMIT,
  localparam int CNT_W   = $clog2(MAX_ALL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             zero_cross_i,
  input  logic             pol_cmp_i,
  output logic             busy_o,
  output logic             overrange_o,
  output logic             underrange_o,
  output logic             polarity_o,
  output logic             load_o,
  output logic [CNT_W-1:0] count_o
);
  dsc_phase_e       phase;
  logic [CNT_W-1:0] cnt;
  logic             si_start, ri_start, end_ok, end_ovr;

  dsc_phase_ctrl #(
    .AZ_CNT(AZ_CNT), .SI_CNT(SI_CNT), .OR_LIMIT(OR_LIMIT), .CNT_W(CNT_W)
  ) u_phase (
    .clk(clk), .rst(rst), .zc_i(zero_cross_i),
    .phase_o(phase), .cnt_o(cnt),
    .si_start_o(si_start), .ri_start_o(ri_start),
    .end_ok_o(end_ok), .end_ovr_o(end_ovr)
  );

  dsc_status #(.UR_MAX(UR_MAX), .CNT_W(CNT_W)) u_status (
    .clk(clk), .rst(rst),
    .si_start_i(si_start), .ri_start_i(ri_start),
    .end_ok_i(end_ok), .end_ovr_i(end_ovr),
    .pol_i(pol_cmp_i), .cnt_i(cnt),
    .busy_o(busy_o), .ovr_o(overrange_o), .ur_o(underrange_o), .pol_o(polarity_o)
  );

  dsc_result #(.OR_LIMIT(OR_LIMIT), .CNT_W(CNT_W)) u_result (
    .clk(clk), .rst(rst),
    .end_ok_i(end_ok), .end_ovr_i(end_ovr), .cnt_i(cnt),
    .load_o(load_o), .result_o(count_o)
  );

  AST_NO_BUSY_IN_AZ: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_AZ || phase == PH_DONE) |-> !busy_o); // R2

  AST_BUSY_IN_INTEG: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SI || phase == PH_RI) |-> busy_o); // R4

  AST_LOAD_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |=> load_o); // R8

  AST_POL_AT_RI_ONLY: assert property (@(posedge clk) disable iff (rst)
    !$stable(polarity_o) |-> (phase == PH_RI) && ($past(phase) == PH_SI)); // R3

endmodule

// File: tb/dual_slope_seq_bench.sv
module dual_slope_seq_bench;
  localparam int AZ  = 13;
  localparam int SI  = 10;
  localparam int ORL = 40;
  localparam int URM = 6;
  localparam int MA  = (AZ > SI) ? AZ : SI;
  localparam int MX  = (MA > ORL) ? MA : ORL;
  localparam int RW  = $clog2(MX + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic zc  = 1'b0;
  logic pin = 1'b0;
  logic busy, ovr, ur, pol, load;
  logic [RW-1:0] res;

  int checks = 0;
  int errors = 0;
  bit exp_ovr = 1'b0, exp_ur = 1'b0, exp_pol = 1'b0;
  bit after_load = 1'b0;
  int last_res = 0;

  always #5 clk = ~clk;

  dual_slope_seq #(.AZ_CNT(AZ), .SI_CNT(SI), .OR_LIMIT(ORL), .UR_MAX(URM)) u_dual_slope_seq (
    .clk(clk), .rst(rst), .zero_cross_i(zc), .pol_cmp_i(pin),
    .busy_o(busy), .overrange_o(ovr), .underrange_o(ur), .polarity_o(pol),
    .load_o(load), .count_o(res)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_under(input int k);
    return k <= URM;
  endfunction

  function automatic int exp_result(input int k);
    return (k > ORL) ? ORL : k;
  endfunction

  // Starts at the negedge right after an edge that put the block at the first auto-zero clock.
  task automatic convert(input int k, input bit p, input bit noise);
    int n = 0;
    while (n < AZ + 5) begin
      @(negedge clk);
      n++;
      if (n == 1 && after_load) begin
        chk(load == 1'b0, "R8 load lasts one clock", int'(load), 0);
        chk(int'(res) == last_res, "R8 count held after load", int'(res), last_res);
        chk(ovr == exp_ovr, "R6 overrange held in auto-zero", int'(ovr), int'(exp_ovr));
        chk(ur == exp_ur, "R7 underrange held in auto-zero", int'(ur), int'(exp_ur));
      end
      if (busy) break;
      zc = noise ? 1'($urandom % 2) : 1'b0;
    end
    chk(n == AZ, "R2 auto-zero length (R9 with glitches)", n, AZ);
    chk(ur == 1'b0, "R7 underrange cleared at busy rise", int'(ur), 0);
    chk(ovr == exp_ovr, "R6 overrange held into signal integrate", int'(ovr), int'(exp_ovr));
    chk(pol == exp_pol, "R3 polarity held until reference start", int'(pol), int'(exp_pol));
    for (int i = 0; i < SI; i++) begin
      pin = (i == SI - 1) ? p : ~p;
      zc  = noise ? 1'($urandom % 2) : 1'b0;
      @(negedge clk);
      if (i == SI / 2) begin
        chk(busy == 1'b1, "R2 busy high in signal integrate", int'(busy), 1);
        chk(pol == exp_pol, "R3 polarity held in signal integrate", int'(pol), int'(exp_pol));
      end
    end
    zc  = 1'b0;
    pin = ~p;
    exp_pol = p;
    chk(pol == p, "R3 polarity sampled on last integrate clock", int'(pol), int'(p));
    chk(ovr == 1'b0, "R6 overrange cleared at reference start", int'(ovr), 0);
    chk(busy == 1'b1, "R4 busy high at reference start", int'(busy), 1);
    if (k <= ORL) begin
      repeat (k) @(negedge clk);
      chk(busy == 1'b1, "R4 busy held until crossing", int'(busy), 1);
      zc = 1'b1;
      @(negedge clk);
      zc = 1'b0;
      exp_ovr = 1'b0;
      exp_ur  = exp_under(k);
      chk(busy == 1'b0, "R4 busy falls on crossing", int'(busy), 0);
      chk(ur == exp_ur, "R7 underrange at busy fall", int'(ur), int'(exp_ur));
      chk(ovr == 1'b0, "R5 no overrange on crossing", int'(ovr), 0);
    end else begin
      repeat (ORL) @(negedge clk);
      chk(busy == 1'b1, "R5 busy held up to limit", int'(busy), 1);
      @(negedge clk);
      exp_ovr = 1'b1;
      exp_ur  = 1'b0;
      chk(busy == 1'b0, "R5 busy falls at limit", int'(busy), 0);
      chk(ovr == 1'b1, "R5 overrange set", int'(ovr), 1);
      chk(ur == 1'b0, "R7 no underrange on overrange", int'(ur), 0);
    end
    @(negedge clk);
    last_res = exp_result(k);
    chk(load == 1'b1, "R8 load after busy fall", int'(load), 1);
    chk(int'(res) == last_res, "R4 result count", int'(res), last_res);
    after_load = 1'b1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    zc  = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy cleared", int'(busy), 0);
    chk(ovr == 1'b0, "R1 overrange cleared", int'(ovr), 0);
    chk(ur == 1'b0, "R1 underrange cleared", int'(ur), 0);
    chk(pol == 1'b0, "R1 polarity cleared", int'(pol), 0);
    chk(load == 1'b0, "R1 load low", int'(load), 0);
    chk(res == '0, "R1 count cleared", int'(res), 0);
    rst = 1'b0;
    exp_ovr = 1'b0;
    exp_ur = 1'b0;
    exp_pol = 1'b0;
    after_load = 1'b0;
    last_res = 0;
  endtask

  initial begin
    void'($urandom(32'd7151));
    do_reset();
    convert(0, 1'b1, 1'b0);
    convert(URM, 1'b0, 1'b0);
    convert(URM + 1, 1'b1, 1'b1);
    convert(ORL, 1'b0, 1'b0);
    convert(ORL + 1, 1'b1, 1'b0);
    convert(ORL + 3, 1'b0, 1'b1);
    convert(5, 1'b1, 1'b1);
    convert(0, 1'b0, 1'b0);
    for (int j = 0; j < 20; j++) begin
      convert(int'($urandom_range(0, ORL + 3)), 1'($urandom % 2), 1'($urandom % 2));
    end
    // R10: reset in the middle of reference integration
    begin
      int w = 0;
      while (!busy && w < AZ + 5) begin
        @(negedge clk);
        w++;
      end
      repeat (SI + 3) @(negedge clk);
      do_reset();
      convert(9, 1'b1, 1'b0);
      chk(ur == 1'b0, "R10 normal cycle after mid reset", int'(ur), 0);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule